// File: doc/BRIEF.md
# Hypercube Dimension-Ordered Router Node

This block is the switching node for one vertex of a binary hypercube with `DIM` dimensions. It has `DIM+1` ports. Port 0 is the local port, which injects and ejects packets for the attached processing element. Port `k+1` is the link to the neighbour whose label differs from this node's label in bit `k` alone. Every packet is a single flit. It carries a destination label that is `DIM` bits wide and an opaque payload that is `PW` bits wide.

For each arriving packet the node takes the XOR of its own label (`NODE_ID`) and the destination. A zero result sends the packet out of the local port. Any other result sends it out of the neighbour port for the lowest set bit of the difference. Because every node on the path repeats this rule, a packet crosses dimensions in ascending order. It reaches its target in as many hops as the two labels have differing bits, which is never more than `DIM`.

Each output port has a single register stage. When several inputs want the same output in the same cycle, the lowest-numbered input wins. The other inputs see `in_ready` low and must hold their packet unchanged. An output register loads only when it is empty or when its downstream `out_ready` is high in that cycle, so back-pressure reaches the inputs in the same cycle. `in_ready[i]` is asserted only while `in_valid[i]` is high, and it means that the packet is taken at the next clock edge.

Top module: `ecube_router_node`

## Requirements
- R1: A packet whose destination equals `NODE_ID` leaves on output port 0 (local).
- R2: A packet whose destination differs from `NODE_ID` leaves on output port `k+1`, where `k` is the index of the least significant 1 bit in `NODE_ID ^ dest`.
- R3: The destination label and the payload come out unchanged.
- R4: A packet taken at a clock edge (in_valid and in_ready both high) is presented, with `out_valid` high, right after that same edge.
- R5: While an output holds a packet and its `out_ready` is low, `out_valid` stays high and `out_dest`/`out_data` stay stable, and any input aimed at that output sees `in_ready` low.
- R6: When several valid inputs target the same output in one cycle, only the lowest-indexed one sees `in_ready` high. The others are taken in later cycles, again in index order.
- R7: While reset is active and just after it, every `out_valid` bit is low.
- R8: With `out_ready` held high, one output takes a new packet every cycle, with no idle cycle between them.
- R9: Inputs aimed at different outputs are all taken in the same cycle.
- R10: Chaining nodes moves a packet from 010 to 111 through node 011, two hops, with dimension 0 crossed before dimension 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | DIM+1 | Per-input packet present; bit 0 is local, bit k+1 is dimension k |
| in_ready | output | DIM+1 | Per-input packet accepted at the next edge |
| in_dest | input | (DIM+1)*DIM | Destination label of each input packet |
| in_data | input | (DIM+1)*PW | Payload of each input packet |
| out_valid | output | DIM+1 | Per-output packet present |
| out_ready | input | DIM+1 | Per-output downstream can take the packet |
| out_dest | output | (DIM+1)*DIM | Destination label on each output |
| out_data | output | (DIM+1)*PW | Payload on each output |

## Verification
The bench builds the node with three dimensions and an 8-bit payload. This gives four ports and eight labels, so every destination, and with it every output port, can be tried from label 010. A second instance with label 011 is chained after the neighbour port of the first. This makes the two-hop journey from 010 to 111 observable. Four inputs are enough to set up contention on one output while the other outputs run in parallel.

// File: rtl/ecube_pkg.sv
package ecube_pkg;

  localparam int PORT_LOCAL = 0;

  // Index of the least significant 1 bit; -1 when the vector is zero.
  function automatic int lowest_set_idx(logic [31:0] v);
    int idx;
    idx = -1;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) idx = k;
    end
    return idx;
  endfunction

endpackage

// File: rtl/ecube_route_calc.sv
module ecube_route_calc #(
  parameter int DIM = 3,
  parameter logic [DIM-1:0] NODE_ID = '0,
  localparam int NP = DIM + 1
) (
  input  logic [DIM-1:0] dest,
  output logic [NP-1:0]  port_sel
);
  logic [DIM-1:0] diff;
  assign diff = NODE_ID ^ dest;

  always_comb begin
    port_sel = '0;
    port_sel[ecube_pkg::PORT_LOCAL] = (diff == '0);
    for (int k = 0; k < DIM; k++) begin
      // dimension k is taken when bit k differs and no lower bit does
      port_sel[k+1] = diff[k] && ((diff & ((DIM'(1) << k) - DIM'(1))) == '0);
    end
  end
endmodule

// File: rtl/ecube_fixed_arb.sv
module ecube_fixed_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // isolate the lowest set request bit: lowest index has priority
  assign grant = req & (~req + N'(1));
endmodule

// File: rtl/ecube_out_stage.sv
module ecube_out_stage #(
  parameter int DIM = 3,
  parameter int PW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [DIM-1:0] ld_dest,
  input  logic [PW-1:0]  ld_data,
  output logic           can_accept,
  output logic           o_valid,
  input  logic           o_ready,
  output logic [DIM-1:0] o_dest,
  output logic [PW-1:0]  o_data
);
  assign can_accept = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_dest  <= '0;
      o_data  <= '0;
    end else begin
      if (can_accept) o_valid <= load;
      if (load) begin
        o_dest <= ld_dest;
        o_data <= ld_data;
      end
    end
  end
endmodule

// File: rtl/ecube_router_node.sv
module ecube_router_node #(
  parameter int DIM = 3,
  parameter logic [DIM-1:0] NODE_ID = 3'b010,
  parameter int PW  = 8,
  localparam int NP = DIM + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NP-1:0]           in_valid,
  output logic [NP-1:0]           in_ready,
  input  logic [NP-1:0][DIM-1:0]  in_dest,
  input  logic [NP-1:0][PW-1:0]   in_data,
  output logic [NP-1:0]           out_valid,
  input  logic [NP-1:0]           out_ready,
  output logic [NP-1:0][DIM-1:0]  out_dest,
  output logic [NP-1:0][PW-1:0]   out_data
);
  logic [NP-1:0][NP-1:0] sel_by_in;   // [input][output]
  logic [NP-1:0][NP-1:0] req_by_out;  // [output][input]
  logic [NP-1:0][NP-1:0] gnt_by_out;  // [output][input]
  logic [NP-1:0]         can_accept;
  logic [NP-1:0]         load;
  logic [NP-1:0][DIM-1:0] mux_dest;
  logic [NP-1:0][PW-1:0]  mux_data;

  genvar gi, go;
  generate
    for (gi = 0; gi < NP; gi++) begin : g_route
      ecube_route_calc #(.DIM(DIM), .NODE_ID(NODE_ID)) u_route (
        .dest     (in_dest[gi]),
        .port_sel (sel_by_in[gi])
      );
    end

    for (go = 0; go < NP; go++) begin : g_out
      always_comb begin
        for (int i = 0; i < NP; i++) begin
          req_by_out[go][i] = in_valid[i] && sel_by_in[i][go];
        end
      end

      ecube_fixed_arb #(.N(NP)) u_arb (
        .req   (req_by_out[go]),
        .grant (gnt_by_out[go])
      );

      always_comb begin
        mux_dest[go] = '0;
        mux_data[go] = '0;
        for (int i = 0; i < NP; i++) begin
          if (gnt_by_out[go][i]) begin
            mux_dest[go] = in_dest[i];
            mux_data[go] = in_data[i];
          end
        end
      end

      assign load[go] = (|gnt_by_out[go]) && can_accept[go];

      ecube_out_stage #(.DIM(DIM), .PW(PW)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load[go]),
        .ld_dest    (mux_dest[go]),
        .ld_data    (mux_data[go]),
        .can_accept (can_accept[go]),
        .o_valid    (out_valid[go]),
        .o_ready    (out_ready[go]),
        .o_dest     (out_dest[go]),
        .o_data     (out_data[go])
      );
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_ready[i] = 1'b0;
      for (int o = 0; o < NP; o++) begin
        if (gnt_by_out[o][i] && can_accept[o]) in_ready[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecube_router_chk.sv
module ecube_router_chk #(
  parameter int DIM = 3,
  parameter logic [DIM-1:0] NODE_ID = '0,
  parameter int PW  = 8,
  localparam int NP = DIM + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NP-1:0]          in_valid,
  input logic [NP-1:0]          in_ready,
  input logic [NP-1:0][DIM-1:0] in_dest,
  input logic [NP-1:0]          out_valid,
  input logic [NP-1:0]          out_ready,
  input logic [NP-1:0][DIM-1:0] out_dest,
  input logic [NP-1:0][PW-1:0]  out_data
);
  int tgt [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      if (in_dest[i] == NODE_ID) tgt[i] = 0;
      else tgt[i] = ecube_pkg::lowest_set_idx(32'(NODE_ID ^ in_dest[i])) + 1;
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) $rose(rst_n) |-> out_valid == '0); // R7

  AST_LOCAL_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> out_dest[0] == NODE_ID); // R1

  genvar k, o, i, j;
  generate
    for (k = 0; k < DIM; k++) begin : g_dim
      AST_DIM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[k+1] |-> (out_dest[k+1] != NODE_ID) &&
          (ecube_pkg::lowest_set_idx(32'(NODE_ID ^ out_dest[k+1])) == k)); // R2
    end
    for (o = 0; o < NP; o++) begin : g_hold
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_dest[o]) && $stable(out_data[o])); // R5
    end
    for (i = 0; i < NP; i++) begin : g_acc
      AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[i] && in_ready[i] |=> out_valid != '0); // R4
      for (j = i + 1; j < NP; j++) begin : g_pair
        AST_LOW_INDEX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
          in_valid[i] && in_valid[j] && (tgt[i] == tgt[j]) |-> !in_ready[j]); // R6
      end
    end
  endgenerate
endmodule

bind ecube_router_node ecube_router_chk #(.DIM(DIM), .NODE_ID(NODE_ID), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_dest   (in_dest),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dest  (out_dest),
  .out_data  (out_data)
);

// File: tb/tb_ecube_router_node.sv
`timescale 1ns/1ps
module tb_ecube_router_node;
  localparam int DIM = 3;
  localparam int PW  = 8;
  localparam int NP  = DIM + 1;
  localparam logic [DIM-1:0] ME  = 3'b010;
  localparam logic [DIM-1:0] NXT = 3'b011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]          in_valid, in_ready, out_valid, out_ready;
  logic [NP-1:0][DIM-1:0] in_dest, out_dest;
  logic [NP-1:0][PW-1:0]  in_data, out_data;

  logic [NP-1:0]          h_in_valid, h_in_ready, h_out_valid, h_out_ready;
  logic [NP-1:0][DIM-1:0] h_in_dest, h_out_dest;
  logic [NP-1:0][PW-1:0]  h_in_data, h_out_data;

  ecube_router_node #(.DIM(DIM), .NODE_ID(ME), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest), .out_data(out_data)
  );

  ecube_router_node #(.DIM(DIM), .NODE_ID(NXT), .PW(PW)) dut_hop (
    .clk(clk), .rst_n(rst_n),
    .in_valid(h_in_valid), .in_ready(h_in_ready), .in_dest(h_in_dest), .in_data(h_in_data),
    .out_valid(h_out_valid), .out_ready(h_out_ready), .out_dest(h_out_dest), .out_data(h_out_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_port(logic [DIM-1:0] node, logic [DIM-1:0] dst);
    logic [DIM-1:0] d;
    d = node ^ dst;
    for (int k = 0; k < DIM; k++) if (d[k]) return k + 1;
    return 0;
  endfunction

  task automatic idle_inputs();
    in_valid = '0; in_dest = '0; in_data = '0;
    h_in_valid = '0; h_in_dest = '0; h_in_data = '0;
  endtask

  task automatic t_reset();
    check("R7 out_valid in reset", 32'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R7 out_valid after reset", 32'(out_valid), 0);
  endtask

  task automatic t_local();
    @(negedge clk);
    in_valid[2] = 1'b1; in_dest[2] = ME; in_data[2] = 8'hA5;
    #1 check("R1 in_ready local", 32'(in_ready[2]), 1);
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R1 R4 local out_valid", 32'(out_valid), 32'b0001);
    check("R3 local data", 32'(out_data[0]), 32'hA5);
    check("R3 local dest", 32'(out_dest[0]), 32'(ME));
  endtask

  task automatic t_route_all();
    for (int d = 0; d < 8; d++) begin
      @(negedge clk);
      in_valid[0] = 1'b1; in_dest[0] = DIM'(d); in_data[0] = 8'(8'h30 + d);
      @(posedge clk); @(negedge clk);
      idle_inputs();
      check("R2 port select", 32'(out_valid), 32'(1) << exp_port(ME, DIM'(d)));
      check("R3 routed data", 32'(out_data[exp_port(ME, DIM'(d))]), 32'(8'h30 + d));
    end
  endtask

  task automatic t_conflict();
    @(negedge clk);
    in_valid[1] = 1'b1; in_dest[1] = 3'b011; in_data[1] = 8'h11;
    in_valid[3] = 1'b1; in_dest[3] = 3'b011; in_data[3] = 8'h33;
    #1 check("R6 winner ready", 32'(in_ready[1]), 1);
    check("R6 loser held", 32'(in_ready[3]), 0);
    @(posedge clk); @(negedge clk);
    in_valid[1] = 1'b0;
    check("R6 first out data", 32'(out_data[1]), 32'h11);
    #1 check("R6 loser now ready", 32'(in_ready[3]), 1);
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R6 second out data", 32'(out_data[1]), 32'h33);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 4'b1011;
    in_valid[0] = 1'b1; in_dest[0] = 3'b000; in_data[0] = 8'h5A;
    @(posedge clk); @(negedge clk);
    in_data[0] = 8'hC3;
    for (int n = 0; n < 3; n++) begin
      #1 check("R5 held valid", 32'(out_valid[2]), 1);
      check("R5 held data", 32'(out_data[2]), 32'h5A);
      check("R5 input stalled", 32'(in_ready[0]), 0);
      @(posedge clk); @(negedge clk);
    end
    out_ready = '1;
    #1 check("R5 released ready", 32'(in_ready[0]), 1);
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R5 next data", 32'(out_data[2]), 32'hC3);
  endtask

  task automatic t_parallel();
    @(negedge clk);
    in_valid = '1;
    in_dest[0] = 3'b011; in_data[0] = 8'h01;
    in_dest[1] = 3'b000; in_data[1] = 8'h02;
    in_dest[2] = 3'b110; in_data[2] = 8'h03;
    in_dest[3] = ME;     in_data[3] = 8'h04;
    #1 check("R9 all ready", 32'(in_ready), 32'hF);
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R9 all out valid", 32'(out_valid), 32'hF);
    check("R9 out0", 32'(out_data[0]), 32'h04);
    check("R9 out1", 32'(out_data[1]), 32'h01);
    check("R9 out2", 32'(out_data[2]), 32'h02);
    check("R9 out3", 32'(out_data[3]), 32'h03);
  endtask

  task automatic t_stream();
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      in_valid[2] = 1'b1; in_dest[2] = 3'b011; in_data[2] = 8'(8'h40 + n);
      if (n > 0) check("R8 stream data", 32'(out_data[1]), 32'(8'h40 + n - 1));
      #1 check("R8 ready every cycle", 32'(in_ready[2]), 1);
      @(posedge clk);
    end
    @(negedge clk);
    idle_inputs();
    check("R8 last data", 32'(out_data[1]), 32'h43);
  endtask

  task automatic t_hop();
    @(negedge clk);
    in_valid[0] = 1'b1; in_dest[0] = 3'b111; in_data[0] = 8'h77;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R10 first hop dim0", 32'(out_valid), 32'b0010);
    h_in_valid[1] = out_valid[1]; h_in_dest[1] = out_dest[1]; h_in_data[1] = out_data[1];
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R10 second hop dim2", 32'(h_out_valid), 32'b1000);
    check("R10 payload after two hops", 32'(h_out_data[3]), 32'h77);
    check("R10 dest after two hops", 32'(h_out_dest[3]), 32'b111);
  endtask

  initial begin
    idle_inputs();
    out_ready = '1;
    h_out_ready = '1;
    repeat (3) @(negedge clk);
    t_reset();
    t_local();
    t_route_all();
    t_conflict();
    t_backpressure();
    t_parallel();
    t_stream();
    t_hop();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule